// File: doc/BRIEF.md
# SATD Intra Mode Decider

This block chooses intra prediction modes for one macroblock from a stream of SATD costs. Each cost arrives with a category tag (4x4 luma, 16x16 luma or chroma) and a mode number. For each category the block keeps the lowest cost seen so far and the mode that produced it. A flag marks the last cost of the macroblock. That cost is accepted like the others and also starts the final decision.

The final decision asks whether the best 4x4 cost, plus a penalty of 24 times the QP-derived value x, is still no worse than the best 16x16 cost. A single add/subtract unit and one 19-bit accumulator build this penalty over several cycles: first 8x, then 16x, then 24x. The next step adds the 4x4 cost to the accumulator. The step after that subtracts the sum from the 16x16 cost, and the sign of the result picks the luma partition. The chosen modes and the partition flag are registered and announced by a one-cycle start pulse for the coder. The running minima then restart for the next macroblock.

Top module: `intra_mode_decider`

## Requirements
- R1: The 4x4 luma category (cost_cat = 0) has candidate modes 0 to 8. At each decision, mode_l4 equals the accepted 4x4 mode with the lowest cost.
- R2: The 16x16 luma category (cost_cat = 1) and the chroma category (cost_cat = 2) each have candidate modes 0 to 3. mode_l16 and mode_chroma equal the lowest-cost accepted mode of their category. If a category received no cost, its mode output is 0.
- R3: When costs are equal within a category, the lower mode number wins, whatever order the costs arrive in.
- R4: These costs are ignored: costs with cost_cat = 3, and costs whose mode number is at or above the mode count of their category.
- R5: From the cycle after the last cost is accepted until the start pulse, cost_valid is ignored and no cost is accepted.
- R6: use_l16 is 1 when the best 16x16 cost is strictly less than the best 4x4 cost plus 24·x. Otherwise use_l16 is 0, so a tie goes to 4x4.
- R7: decision_start is high for exactly one cycle, following the fifth rising edge after the edge that accepts the last cost. The mode outputs and use_l16 change only in that cycle and hold their values until the next decision.
- R8: x is sampled in the same cycle as the last cost. Later changes of penalty_x do not affect that decision.
- R9: After each decision, all three running minima restart, so the next macroblock's result depends only on its own costs.
- R10: After reset, all mode outputs, use_l16 and decision_start are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cost_valid | input | 1 | A cost is present this cycle |
| cost_cat | input | 2 | Category: 0 = 4x4 luma, 1 = 16x16 luma, 2 = chroma, 3 = unused |
| cost_mode | input | 4 | Candidate mode number |
| cost_val | input | 18 | SATD cost, unsigned |
| cost_last | input | 1 | Marks the last cost of the macroblock |
| penalty_x | input | 8 | QP-derived penalty value x |
| mode_l4 | output | 4 | Chosen 4x4 luma mode |
| mode_l16 | output | 4 | Chosen 16x16 luma mode |
| mode_chroma | output | 4 | Chosen chroma mode |
| use_l16 | output | 1 | 1 = 16x16 luma wins, 0 = 4x4 luma wins |
| decision_start | output | 1 | One-cycle start pulse for the coder |

## Verification
If a running minimum is corrupted, or is not cleared after a decision, it shows up at the next start pulse as a wrong mode number or a wrong partition flag. That is five edges after that macroblock's last cost. If the penalty sequence skips or repeats a step, use_l16 goes wrong only when the two luma costs are close. The bench therefore drives exact ties and off-by-one margins. A sequencer that loses its place shows up within one cycle as a start pulse in the wrong cycle or a missing one. Outputs that drift between decisions are caught on the very next clock.

// File: rtl/intra_md_pkg.sv
// Package: shared types for the intra mode decider.
// Assumes: the category codes match the cost_cat encoding at the top ports.
package intra_md_pkg;

    typedef enum logic [1:0] {
        CAT_L4  = 2'd0,
        CAT_L16 = 2'd1,
        CAT_CHR = 2'd2,
        CAT_NONE = 2'd3
    } cat_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_P8   = 3'd1,
        ST_P16  = 3'd2,
        ST_P24  = 3'd3,
        ST_SUM  = 3'd4,
        ST_DIFF = 3'd5
    } seq_e;

endpackage

// File: rtl/md_cat_min.sv
// Module: md_cat_min
// Keeps the lowest cost and its mode for one category of candidates.
// On equal costs the lower mode number is kept, so arrival order does not matter.
// Assumes: clr and upd are never high together in a useful way (clr wins).
module md_cat_min #(
    parameter int COST_W    = 18,
    parameter int MODE_W    = 4,
    parameter int NUM_MODES = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [COST_W-1:0] cost_i,
    output logic [COST_W-1:0] best_cost,
    output logic [MODE_W-1:0] best_mode
);
    localparam logic [MODE_W-1:0] MODE_LIM = MODE_W'(NUM_MODES);

    logic in_range;
    logic better;
    logic take;

    // Decide whether the offered candidate replaces the held one.
    always_comb begin
        in_range = (mode_i < MODE_LIM);
        better   = (cost_i < best_cost) ||
                   ((cost_i == best_cost) && (mode_i < best_mode));
        take     = upd && in_range && better;
    end

    // Hold the running minimum; restart at the largest cost on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            best_cost <= '1;
            best_mode <= '0;
        end else if (take) begin
            best_cost <= cost_i;
            best_mode <= mode_i;
        end
    end

    a_r4_mode_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        best_mode < MODE_LIM);

    a_r1_min_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> best_cost <= $past(best_cost));

endmodule

// File: rtl/md_penalty_seq.sv
// Module: md_penalty_seq
// Builds 24*x in one accumulator over three cycles, using a single shared
// add/subtract unit. It then adds the best 4x4 cost and subtracts the sum
// from the best 16x16 cost. The borrow of that subtraction selects 16x16.
// Assumes: best4_i and best16_i stay stable while busy is high.
module md_penalty_seq
    import intra_md_pkg::*;
#(
    parameter int COST_W = 18,
    parameter int PEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [PEN_W-1:0]  pen_i,
    input  logic [COST_W-1:0] best4_i,
    input  logic [COST_W-1:0] best16_i,
    output logic              busy,
    output logic              decide,
    output logic              pick16
);
    localparam int ACC_W = COST_W + 1;
    localparam int SHIFT = 3;

    seq_e             state;
    logic [PEN_W-1:0] x_q;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] x8;
    logic [ACC_W-1:0] op_a;
    logic [ACC_W-1:0] op_b;
    logic             op_sub;
    logic [ACC_W:0]   res;
    logic [ACC_W-1:0] acc_next;

    // Route the operands of the shared add/subtract unit for each step.
    always_comb begin
        x8     = ACC_W'(x_q) << SHIFT;
        op_a   = '0;
        op_b   = '0;
        op_sub = 1'b0;
        unique case (state)
            ST_P8:           op_b = x8;
            ST_P16, ST_P24:  begin op_a = acc; op_b = x8; end
            ST_SUM:          begin op_a = acc; op_b = ACC_W'(best4_i); end
            ST_DIFF:         begin op_a = ACC_W'(best16_i); op_b = acc; op_sub = 1'b1; end
            default:         ;
        endcase
    end

    // The single add/subtract unit, with the accumulator saturating on carry.
    always_comb begin
        res      = op_sub ? ({1'b0, op_a} - {1'b0, op_b})
                          : ({1'b0, op_a} + {1'b0, op_b});
        acc_next = res[ACC_W] ? '1 : res[ACC_W-1:0];
    end

    // Status and decision outputs; a borrow on the last step means 16x16 is cheaper.
    always_comb begin
        busy   = (state != ST_IDLE);
        decide = (state == ST_DIFF);
        pick16 = decide && res[ACC_W];
    end

    // Step through the penalty, sum and difference states once per decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            x_q   <= '0;
            acc   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (go) begin
                    state <= ST_P8;
                    x_q   <= pen_i;
                end
                ST_P8:   begin acc <= acc_next; state <= ST_P16; end
                ST_P16:  begin acc <= acc_next; state <= ST_P24; end
                ST_P24:  begin acc <= acc_next; state <= ST_SUM; end
                ST_SUM:  begin acc <= acc_next; state <= ST_DIFF; end
                ST_DIFF: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r6_eight_x: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_P16 |-> acc == ACC_W'(x_q) * ACC_W'(8));

    a_r6_twentyfour_x: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SUM |-> acc == ACC_W'(x_q) * ACC_W'(24));

    a_r8_pen_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(x_q));

    a_r7_sum_to_diff: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SUM |=> decide);

endmodule

// File: rtl/intra_mode_decider.sv
// Module: intra_mode_decider (top)
// Accepts tagged SATD costs and keeps the best mode for each of three
// categories. After the last cost it runs the penalty sequence, then
// registers the chosen modes and the luma partition flag and pulses
// decision_start. Costs offered while a decision is running are dropped.
// Assumes: one macroblock's costs end with exactly one cost_last.
module intra_mode_decider
    import intra_md_pkg::*;
#(
    parameter int COST_W    = 18,
    parameter int MODE_W    = 4,
    parameter int PEN_W     = 8,
    parameter int L4_MODES  = 9,
    parameter int L16_MODES = 4,
    parameter int CHR_MODES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cost_valid,
    input  logic [1:0]        cost_cat,
    input  logic [MODE_W-1:0] cost_mode,
    input  logic [COST_W-1:0] cost_val,
    input  logic              cost_last,
    input  logic [PEN_W-1:0]  penalty_x,
    output logic [MODE_W-1:0] mode_l4,
    output logic [MODE_W-1:0] mode_l16,
    output logic [MODE_W-1:0] mode_chroma,
    output logic              use_l16,
    output logic              decision_start
);
    localparam int NUM_CAT = 3;

    logic              busy;
    logic              decide;
    logic              pick16;
    logic              accept;
    logic              go;
    logic [NUM_CAT-1:0] upd;
    logic [COST_W-1:0] best_cost [NUM_CAT];
    logic [MODE_W-1:0] best_mode [NUM_CAT];

    // Accept a cost only while no decision is in flight.
    always_comb begin
        accept = cost_valid && !busy;
        go     = accept && cost_last;
    end

    // One running-minimum tracker per category; the mode count picks the range.
    for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
        localparam int NM = (c == int'(CAT_L4))  ? L4_MODES :
                            (c == int'(CAT_L16)) ? L16_MODES : CHR_MODES;

        assign upd[c] = accept && (cost_cat == 2'(c));

        md_cat_min #(
            .COST_W   (COST_W),
            .MODE_W   (MODE_W),
            .NUM_MODES(NM)
        ) i_min (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (decide),
            .upd      (upd[c]),
            .mode_i   (cost_mode),
            .cost_i   (cost_val),
            .best_cost(best_cost[c]),
            .best_mode(best_mode[c])
        );

        a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
            decide |=> (&best_cost[c]) && (best_mode[c] == '0));
    end

    md_penalty_seq #(
        .COST_W(COST_W),
        .PEN_W (PEN_W)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .pen_i   (penalty_x),
        .best4_i (best_cost[CAT_L4]),
        .best16_i(best_cost[CAT_L16]),
        .busy    (busy),
        .decide  (decide),
        .pick16  (pick16)
    );

    // Register the chosen modes and partition flag at the decision step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_l4        <= '0;
            mode_l16       <= '0;
            mode_chroma    <= '0;
            use_l16        <= 1'b0;
            decision_start <= 1'b0;
        end else begin
            decision_start <= decide;
            if (decide) begin
                mode_l4     <= best_mode[CAT_L4];
                mode_l16    <= best_mode[CAT_L16];
                mode_chroma <= best_mode[CAT_CHR];
                use_l16     <= pick16;
            end
        end
    end

    a_r7_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        decision_start |=> !decision_start);

    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !decision_start |-> $stable({mode_l4, mode_l16, mode_chroma, use_l16}));

    a_r5_go_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy && !decision_start);

endmodule

// File: tb/test_intra_mode_decider.sv
`timescale 1ns/1ps
module test_intra_mode_decider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cost_valid = 1'b0;
    logic [1:0] cost_cat = 2'd0;
    logic [3:0] cost_mode = 4'd0;
    logic [17:0] cost_val = 18'd0;
    logic       cost_last = 1'b0;
    logic [7:0] penalty_x = 8'd0;
    logic [3:0] mode_l4, mode_l16, mode_chroma;
    logic       use_l16, decision_start;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    intra_mode_decider i_intra_mode_decider (
        .clk(clk), .rst_n(rst_n), .cost_valid(cost_valid), .cost_cat(cost_cat),
        .cost_mode(cost_mode), .cost_val(cost_val), .cost_last(cost_last),
        .penalty_x(penalty_x), .mode_l4(mode_l4), .mode_l16(mode_l16),
        .mode_chroma(mode_chroma), .use_l16(use_l16), .decision_start(decision_start)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cost[3];
    int m_mode[3];
    int pend = 0;
    int m_x  = 0;
    int e_l4 = 0, e_l16 = 0, e_chr = 0, e_use = 0, e_start = 0;

    function automatic int lim_of(int c);
        return (c == 0) ? 9 : 4;
    endfunction

    task automatic model_clear();
        for (int c = 0; c < 3; c++) begin
            m_cost[c] = 262143;
            m_mode[c] = 0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
            pend = 0; m_x = 0;
            e_l4 = 0; e_l16 = 0; e_chr = 0; e_use = 0; e_start = 0;
        end else begin
            e_start = 0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    e_l4 = m_mode[0]; e_l16 = m_mode[1]; e_chr = m_mode[2];
                    e_use = (m_cost[1] < m_cost[0] + 24 * m_x) ? 1 : 0;
                    e_start = 1;
                    model_clear();
                end
            end else if (cost_valid) begin
                int c, md, cv;
                c = int'(cost_cat); md = int'(cost_mode); cv = int'(cost_val);
                if (c < 3 && md < lim_of(c)) begin
                    if (cv < m_cost[c] || (cv == m_cost[c] && md < m_mode[c])) begin
                        m_cost[c] = cv;
                        m_mode[c] = md;
                    end
                end
                if (cost_last) begin
                    pend = 5;
                    m_x = int'(penalty_x);
                end
            end
        end
    end

    // Compare every output against the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(decision_start) == e_start, "R7 decision_start", int'(decision_start), e_start);
            chk(int'(use_l16) == e_use, "R6 use_l16", int'(use_l16), e_use);
            chk(int'(mode_l4) == e_l4, "R1 mode_l4", int'(mode_l4), e_l4);
            chk(int'(mode_l16) == e_l16, "R2 mode_l16", int'(mode_l16), e_l16);
            chk(int'(mode_chroma) == e_chr, "R2 mode_chroma", int'(mode_chroma), e_chr);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(input int cat, input int md, input int cv, input bit last);
        cost_valid = 1'b1;
        cost_cat   = 2'(cat);
        cost_mode  = 4'(md);
        cost_val   = 18'(cv);
        cost_last  = last;
        @(negedge clk);
        cost_valid = 1'b0;
        cost_last  = 1'b0;
    endtask

    task automatic wait_start(input string tag);
        int n = 0;
        while (decision_start !== 1'b1 && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(decision_start === 1'b1, tag, int'(decision_start), 1);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 50000);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(mode_l4 == 0, "R10 mode_l4 after reset", int'(mode_l4), 0);
        chk(mode_l16 == 0, "R10 mode_l16 after reset", int'(mode_l16), 0);
        chk(mode_chroma == 0, "R10 mode_chroma after reset", int'(mode_chroma), 0);
        chk(use_l16 == 0, "R10 use_l16 after reset", int'(use_l16), 0);
        chk(decision_start == 0, "R10 decision_start after reset", int'(decision_start), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Macroblock 1: plain minima in all categories (R1, R2), 1300 vs 1000+240 -> 4x4 (R6)
        penalty_x = 8'd10;
        begin
            int c4[9]  = '{1500, 1200, 1100, 1900, 1050, 1000, 1300, 1400, 1600};
            int c16[4] = '{1400, 1350, 1300, 1310};
            int cch[4] = '{700, 650, 900, 800};
            for (int m = 0; m < 9; m++) send(0, m, c4[m], 1'b0);
            for (int m = 0; m < 4; m++) send(1, m, c16[m], 1'b0);
            for (int m = 0; m < 4; m++) send(2, m, cch[m], m == 3);
        end
        // R7: the pulse follows the fifth edge after the accepting edge
        repeat (4) @(negedge clk);
        chk(decision_start == 0, "R7 no pulse before fifth edge", int'(decision_start), 0);
        @(negedge clk);
        chk(decision_start == 1, "R7 pulse after fifth edge", int'(decision_start), 1);
        chk(mode_l4 == 5, "R1 best 4x4 mode", int'(mode_l4), 5);
        chk(mode_l16 == 2, "R2 best 16x16 mode", int'(mode_l16), 2);
        chk(mode_chroma == 1, "R2 best chroma mode", int'(mode_chroma), 1);
        chk(use_l16 == 0, "R6 4x4 wins by margin", int'(use_l16), 0);
        @(negedge clk);

        // Macroblock 2: equal costs out of order (R3), exact tie on partition (R6)
        penalty_x = 8'd20;
        send(0, 7, 500, 1'b0);
        send(0, 3, 500, 1'b0);
        send(0, 8, 600, 1'b0);
        send(1, 3, 980, 1'b0);
        send(1, 1, 980, 1'b0);
        send(2, 2, 50, 1'b0);
        send(2, 0, 50, 1'b1);
        wait_start("R7 pulse for macroblock 2");
        chk(mode_l4 == 3, "R3 tie keeps lower 4x4 mode", int'(mode_l4), 3);
        chk(mode_l16 == 1, "R3 tie keeps lower 16x16 mode", int'(mode_l16), 1);
        chk(mode_chroma == 0, "R3 tie keeps lower chroma mode", int'(mode_chroma), 0);
        chk(use_l16 == 0, "R6 exact tie goes to 4x4", int'(use_l16), 0);
        @(negedge clk);

        // Macroblock 3: out-of-range costs (R4), x changed after last (R8), costs while busy (R5)
        penalty_x = 8'd20;
        send(3, 0, 0, 1'b0);
        send(0, 9, 0, 1'b0);
        send(0, 15, 0, 1'b0);
        send(1, 4, 0, 1'b0);
        send(2, 7, 0, 1'b0);
        send(0, 2, 500, 1'b0);
        send(1, 0, 979, 1'b0);
        penalty_x = 8'd20;
        send(2, 3, 10, 1'b1);
        penalty_x = 8'd0;
        for (int k = 0; k < 4; k++) send(0, 8, 0, 1'b0);
        wait_start("R7 pulse for macroblock 3");
        chk(mode_l4 == 2, "R4 out-of-range 4x4 costs ignored", int'(mode_l4), 2);
        chk(mode_l16 == 0, "R4 out-of-range 16x16 cost ignored", int'(mode_l16), 0);
        chk(mode_chroma == 3, "R4 out-of-range chroma cost ignored", int'(mode_chroma), 3);
        chk(use_l16 == 1, "R8 16x16 wins by one with sampled x", int'(use_l16), 1);
        @(negedge clk);
        chk(decision_start == 0, "R7 pulse lasts one cycle", int'(decision_start), 0);
        chk(mode_l4 == 2, "R7 outputs hold after pulse", int'(mode_l4), 2);

        // Macroblock 4: minima restart (R9); busy-time costs left nothing behind (R5)
        penalty_x = 8'd0;
        send(0, 4, 5000, 1'b0);
        send(1, 3, 6000, 1'b1);
        wait_start("R7 pulse for macroblock 4");
        chk(mode_l4 == 4, "R5 costs sent while busy were dropped", int'(mode_l4), 4);
        chk(mode_l16 == 3, "R9 16x16 minimum restarted", int'(mode_l16), 3);
        chk(mode_chroma == 0, "R9 empty chroma gives mode 0", int'(mode_chroma), 0);
        chk(use_l16 == 0, "R6 6000 vs 5000 keeps 4x4", int'(use_l16), 0);
        @(negedge clk);

        // Random macroblocks, checked by the per-cycle model (R1, R2, R6, R7)
        for (int mb = 0; mb < 12; mb++) begin
            int n = 3 + int'($urandom_range(0, 14));
            penalty_x = 8'($urandom_range(0, 255));
            for (int k = 0; k < n; k++) begin
                int cv = (mb % 3 == 0) ? int'($urandom_range(0, 262143))
                                       : int'($urandom_range(1000, 1040));
                send(int'($urandom_range(0, 3)), int'($urandom_range(0, 10)), cv, k == n - 1);
                if ($urandom_range(0, 3) == 0) penalty_x = 8'($urandom_range(0, 255));
            end
            wait_start("R7 pulse for random macroblock");
            repeat (int'($urandom_range(0, 2))) @(negedge clk);
        end

        repeat (5) @(negedge clk);
        summary();
    end

endmodule